// File: doc/BRIEF.md
# Gated Pulse Counter

This block counts how many pulses arrive on an external count line while a separate gate line is held high, and hands over the total once the gate closes. The count line and the gate line come from unrelated clock domains. Each one passes through a two-stage synchronizer clocked by the system clock. The synchronized count line then goes through a filter that takes on a new level only after that level has been sampled for a fixed number of consecutive cycles. Short spikes and short dips on the count line therefore never reach the counter.

A rising gate opens a window and zeroes the running total. While the window is open, each accepted low-to-high transition of the filtered count line adds one. The running total runs from zero up to a programmable top value; the transition that arrives while the total equals the top value wraps it back to zero and marks the window as overflowed. A falling gate closes the window. The total and the overflow mark are then loaded into output registers, and a strobe is raised for a single cycle.

Top module: `gated_pulse_counter`

## Requirements
- R1: While the synchronized gate is high, every low-to-high transition of the filtered count line adds exactly one to the running total.
- R2: Transitions of the count line that occur while the gate is low leave the total unchanged and produce no strobe.
- R3: A rising gate sets the running total and the overflow mark to zero. If a count transition is accepted in the same cycle as the gate rise, the clear takes priority and the window starts at zero.
- R4: A falling gate loads the running total into `count_o` and the overflow mark into `ovf_o`, and raises `valid_o` for exactly one cycle. Both outputs then hold until the next falling gate.
- R5: The filter adopts a new count-line level only after FILT_LEN consecutive samples at that level (8 by default). A high pulse or a low dip of FILT_LEN-1 samples has no effect, while one of FILT_LEN samples is taken.
- R6: The running total never exceeds TOP. An accepted transition at TOP returns the total to zero and sets the overflow mark, which is reported through `ovf_o` when that window closes.
- R7: While `rst_n` is low, `count_o`, `ovf_o` and `valid_o` are zero and the filter output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | 1 | Raw count line, asynchronous |
| gate_in | input | 1 | Raw gate line, asynchronous |
| count_o | output | CNT_W | Total captured at the last gate fall |
| valid_o | output | 1 | One-cycle strobe when a new total is captured |
| ovf_o | output | 1 | Wrap occurred during the captured window |

## Verification
The bench places count pulses of exactly FILT_LEN and FILT_LEN-1 samples, and dips of FILT_LEN-1 samples inside a high pulse. A filter that is off by one would count the spikes, miss the legal pulses, or split a pulse into two. Some windows hold exactly TOP+1 pulses and others TOP+3, and a clean window follows an overflowed one. A counter that wraps one step early or late, or that keeps a stale overflow mark, shows a wrong total or a wrong flag. One pulse is timed so that its accepted transition lands in the cycle of the gate rise; a design that lets the increment win reports one extra. Pulses sent while the gate is closed would show up in the next total, or as a strobe that was not expected.

// File: rtl/gated_pulse_counter.sv
module gated_pulse_counter #(
  parameter int CNT_W    = 16,
  parameter int TOP      = 20000,
  parameter int FILT_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_in,
  input  logic             gate_in,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o,
  output logic             ovf_o
);
  localparam int RUN_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);
  localparam logic [CNT_W-1:0] TOP_V    = CNT_W'(TOP);

  logic [1:0]       gsync, csync;
  logic             gate_d, filt;
  logic [RUN_W-1:0] run;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  wire gate_s    = gsync[1];
  wire gate_rise = gate_s & ~gate_d;
  wire gate_fall = ~gate_s & gate_d;
  wire differs   = csync[1] != filt;
  wire accept    = differs && (run == RUN_LAST);
  wire cnt_edge  = accept && csync[1];
  wire at_top    = cnt_q == TOP_V;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gsync  <= '0;
      csync  <= '0;
      gate_d <= 1'b0;
    end else begin
      gsync  <= {gsync[0], gate_in};
      csync  <= {csync[0], cnt_in};
      gate_d <= gate_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt <= 1'b0;
      run  <= '0;
    end else if (!differs) begin
      run <= '0;
    end else if (accept) begin
      filt <= csync[1];
      run  <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (gate_rise) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (gate_s && cnt_edge) begin
      if (at_top) begin
        cnt_q <= '0;
        ovf_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= gate_fall;
      if (gate_fall) begin
        count_o <= cnt_q;
        ovf_o   <= ovf_q;
      end
    end
  end
endmodule

// File: rtl/gated_pulse_counter_chk.sv
module gated_pulse_counter_chk #(
  parameter int CNT_W = 16,
  parameter int TOP   = 20000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_s,
  input logic             gate_d,
  input logic             filt,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_q,
  input logic [CNT_W-1:0] count_o,
  input logic             valid_o
);
  p_valid_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_capture_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(count_o));

  p_clear_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_s && !gate_d) |=> (cnt_q == '0 && !ovf_q));

  p_gate_low_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_s |=> $stable(cnt_q));

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  p_below_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TOP));

  p_wrap_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_s && gate_d && $rose(ovf_q)) |-> (cnt_q == '0));

  p_reset_filter_r7: assert property (@(posedge clk)
    !rst_n |=> !filt);
endmodule

bind gated_pulse_counter gated_pulse_counter_chk #(.CNT_W(CNT_W), .TOP(TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_s(gate_s), .gate_d(gate_d), .filt(filt),
  .cnt_q(cnt_q), .ovf_q(ovf_q), .count_o(count_o), .valid_o(valid_o)
);

// File: tb/gated_pulse_counter_bench.sv
module gated_pulse_counter_bench;
  localparam int CNT_W = 16;
  localparam int TOP   = 9;
  localparam int FL    = 8;

  logic clk = 1'b0, rst_n = 1'b0, cnt_in = 1'b0, gate_in = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic valid_o, ovf_o;

  gated_pulse_counter #(.CNT_W(CNT_W), .TOP(TOP), .FILT_LEN(FL)) u_gated_pulse_counter (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .gate_in(gate_in),
    .count_o(count_o), .valid_o(valid_o), .ovf_o(ovf_o));

  always #5 clk = ~clk;

  typedef struct {int cnt; bit ovf; string req;} exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      cnt_in = 1'b1; step(hi);
      cnt_in = 1'b0; step(lo);
    end
  endtask

  task automatic expect_total(int n, string req);
    exp_t e;
    e.cnt = n % (TOP + 1);
    e.ovf = n > TOP;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic window(int n, int hi, int lo, string req);
    expect_total(n, req);
    gate_in = 1'b1; step(12);
    pulses(n, hi, lo);
    step(12);
    gate_in = 1'b0; step(20);
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 unexpected strobe", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(count_o == CNT_W'(e.cnt), {e.req, " count"}, int'(count_o), e.cnt);
        check(ovf_o == e.ovf, {e.req, " ovf"}, int'(ovf_o), int'(e.ovf));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    step(4);
    check(count_o == '0, "R7 count_o in reset", int'(count_o), 0);
    check(valid_o == 1'b0, "R7 valid_o in reset", int'(valid_o), 0);
    check(ovf_o == 1'b0, "R7 ovf_o in reset", int'(ovf_o), 0);
    rst_n = 1'b1; step(5);

    window(3, 12, 12, "R1 basic");
    pulses(4, 12, 12);
    step(10);
    window(2, 12, 12, "R2 gate-low pulses ignored");
    window(12, 12, 12, "R6 wrap past top");
    window(1, 12, 12, "R3 overflow cleared");
    window(TOP + 1, 12, 12, "R6 exact wrap");
    window(TOP, 12, 12, "R6 at top no wrap");

    expect_total(2, "R5 short spikes rejected");
    gate_in = 1'b1; step(12);
    pulses(4, FL - 1, 20);
    pulses(2, FL, 10);
    step(12); gate_in = 1'b0; step(20);

    expect_total(1, "R5 short dip rejected");
    gate_in = 1'b1; step(12);
    cnt_in = 1'b1; step(12);
    cnt_in = 1'b0; step(FL - 1);
    cnt_in = 1'b1; step(12);
    cnt_in = 1'b0; step(12);
    step(12); gate_in = 1'b0; step(20);

    expect_total(2, "R3 clear beats coincident edge");
    cnt_in = 1'b1; step(7);
    gate_in = 1'b1; step(5);
    cnt_in = 1'b0; step(12);
    pulses(2, 12, 12);
    step(12); gate_in = 1'b0; step(20);

    window(0, 12, 12, "R4 empty window");
    step(10);
    check(valid_o == 1'b0, "R4 strobe single cycle", int'(valid_o), 0);
    check(q.size() == 0, "R4 all captures seen", q.size(), 0);
    finish_run();
  end
endmodule